// File: doc/BRIEF.md
# Triggered DAC Channel Wave Front End

This block is the digital side of a single converter channel. Software programs a control word and supplies 12-bit sample codes through a data input port. Each accepted code is held in a holding register. From there it is copied to the output register that drives the converter, and that copy happens in one of two ways. With triggering off, the output follows the holding register one clock later. With triggering on, the copy waits for a selected trigger event and completes three clocks after it.

While triggering is on, a wave mode can add an offset to the held code on each trigger. Noise mode adds a masked pseudo-random value. Triangle mode adds a counter that ramps up and down. One 4-bit selector field sets both the noise mask width and the triangle peak. The control word also carries DMA request and underrun interrupt enables for neighbouring logic, and a calibration flag that is locked while the channel runs.

The data input is a valid/ready port whose ready output is always high. The block never applies back-pressure, and every cycle with valid high writes the holding register. Control and trigger pins are plain level or pulse signals.

Top module: `dacw_channel`

## Requirements
- R1: Reset (active-low `rst_n`) clears every control field, the holding register and the output code to 0, and `din_ready` reads 1.
- R2: The control word layout is bit 0 enable, bit 1 trigger enable, bits 5:2 trigger select, bits 7:6 wave mode, bits 11:8 mask/amplitude code, bit 12 DMA enable, bit 13 underrun interrupt enable, bit 14 calibration enable. A write with `ctl_we` loads the fields, which read back unchanged on `ctl_rdata`. The DMA and interrupt bits are plain read/write bits.
- R3: The calibration bit takes a written value only if the enable bit was 0 before that write. Otherwise the calibration bit keeps its old value while the other fields still update.
- R4: With enable 1 and trigger enable 0, a code captured into the holding register at clock edge k appears on `dac_code` at edge k+1, with no wave offset.
- R5: With enable 1 and trigger enable 1, a trigger sampled at edge t updates `dac_code` at edge t+3. Select code 0 picks `sw_trig`, and select code k (1..15) picks `ext_trig[k-1]`.
- R6: Trigger inputs that are not selected have no effect. While enable is 0, all triggers and data writes leave `dac_code` unchanged.
- R7: The wave field decodes as 00 none, 01 noise, and 10 or 11 triangle. With trigger enable 0 the wave field has no effect on the output.
- R8: In noise mode, a 12-bit register seeded with 0xACE at reset is sampled on each accepted trigger and then shifted left. The new bit 0 is the XOR of bits 11, 5, 3 and 0. The output is the held code plus the sampled value with bits above the mask code cleared, truncated to 12 bits.
- R9: In triangle mode, a counter starting at 0 is sampled on each accepted trigger. It then counts up by 1 until it equals the peak 2^(n+1)-1, and then counts down by 1 to 0 and repeats. The output is the held code plus the sample, truncated to 12 bits.
- R10: Mask codes 11 to 15 all unmask bits 11:0, which gives a peak of 4095.
- R11: The noise register advances only on accepted triggers in noise mode, and the triangle counter advances only on accepted triggers in triangle mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 15 | Control word to write |
| ctl_rdata | output | 15 | Current control word |
| din_valid | input | 1 | Sample code offered |
| din_ready | output | 1 | Always 1: sample code accepted |
| din_data | input | 12 | Sample code for the holding register |
| sw_trig | input | 1 | Single-cycle software trigger strobe |
| ext_trig | input | 15 | Synchronous single-cycle external trigger pulses |
| dac_code | output | 12 | Output code to the converter |

## Verification
The assertions assume that trigger inputs are synchronous single-cycle pulses and that the control word is changed only by `ctl_we` writes. They also rely on the triangle counter being adjusted only by one step per trigger, which holds as long as the peak is not lowered below the running count mid-ramp. The stimulus drives every input on the falling edge, raises each trigger for one cycle, and keeps the mask code fixed during each triangle sequence.

// File: rtl/dacw_pkg.sv
package dacw_pkg;
  localparam int CTL_W  = 15;
  localparam int TSEL_W = 4;
  localparam int NSRC   = 1 << TSEL_W;
  localparam int AMP_W  = 4;

  typedef struct packed {
    logic              cal_en;
    logic              udr_ie;
    logic              dma_en;
    logic [AMP_W-1:0]  amp;
    logic [1:0]        wave;
    logic [TSEL_W-1:0] tsel;
    logic              trig_en;
    logic              en;
  } ctl_t;

  typedef enum logic [1:0] {
    WM_NONE  = 2'd0,
    WM_NOISE = 2'd1,
    WM_TRI   = 2'd2
  } wmode_e;

  function automatic wmode_e decode_wave(input logic [1:0] w);
    if (w[1]) return WM_TRI;
    if (w[0]) return WM_NOISE;
    return WM_NONE;
  endfunction
endpackage

// File: rtl/dacw_ctrl.sv
module dacw_ctrl
  import dacw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_word,
  output ctl_t             cfg
);
  ctl_t req;
  ctl_t nxt;

  always_comb begin
    req = ctl_t'(wr_word);
    nxt = req;
    // calibration flag is frozen while the channel runs
    if (cfg.en) nxt.cal_en = cfg.cal_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg <= '0;
    else if (wr_en) cfg <= nxt;
  end

  AST_CAL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg.cal_en) |-> !$past(cfg.en)); // R3

  AST_CTL_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg) |-> $past(wr_en)); // R2
endmodule

// File: rtl/dacw_trig.sv
module dacw_trig
  import dacw_pkg::*;
#(
  parameter int DW  = 12,
  parameter int LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              trig_en,
  input  logic [TSEL_W-1:0] tsel,
  input  logic              sw_trig,
  input  logic [NSRC-2:0]   ext_trig,
  input  logic [DW-1:0]     samp_in,
  output logic              hit,
  output logic              fire,
  output logic [DW-1:0]     samp_out
);
  logic [NSRC-1:0] src;
  logic [LAT-1:0]  vld;
  logic [DW-1:0]   smp [LAT];

  assign src = {ext_trig, sw_trig};
  assign hit = en & trig_en & src[tsel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      for (int i = 0; i < LAT; i++) smp[i] <= '0;
    end else begin
      vld[0] <= hit;
      smp[0] <= samp_in;
      for (int i = 1; i < LAT; i++) begin
        vld[i] <= en & vld[i-1];
        smp[i] <= smp[i-1];
      end
    end
  end

  assign fire     = en & vld[LAT-1];
  assign samp_out = smp[LAT-1];
endmodule

// File: rtl/dacw_wave.sv
module dacw_wave
  import dacw_pkg::*;
#(
  parameter int            DW   = 12,
  parameter logic [DW-1:0] SEED = 'hACE,
  parameter logic [DW-1:0] TAPS = 'h829
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  wmode_e           mode,
  input  logic [AMP_W-1:0] amp,
  output logic [DW-1:0]    sample
);
  logic [DW-1:0] mask;
  logic [DW-1:0] lfsr;
  logic [DW-1:0] tri_cnt;
  logic          tri_down;
  logic [DW-1:0] tri_nxt;
  logic          down_nxt;

  // bit b is unmasked when b <= code; codes past the top saturate
  for (genvar b = 0; b < DW; b++) begin : g_mask
    assign mask[b] = (int'(amp) >= b);
  end

  always_comb begin
    tri_nxt  = tri_cnt;
    down_nxt = tri_down;
    if (!tri_down) begin
      if (tri_cnt >= mask) begin
        down_nxt = 1'b1;
        tri_nxt  = tri_cnt - 1'b1;
      end else begin
        tri_nxt  = tri_cnt + 1'b1;
      end
    end else begin
      if (tri_cnt == '0) begin
        down_nxt = 1'b0;
        tri_nxt  = tri_cnt + 1'b1;
      end else begin
        tri_nxt  = tri_cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr     <= SEED;
      tri_cnt  <= '0;
      tri_down <= 1'b0;
    end else if (step) begin
      if (mode == WM_NOISE) lfsr <= {lfsr[DW-2:0], ^(lfsr & TAPS)};
      if (mode == WM_TRI) begin
        tri_cnt  <= tri_nxt;
        tri_down <= down_nxt;
      end
    end
  end

  always_comb begin
    case (mode)
      WM_NOISE: sample = lfsr & mask;
      WM_TRI:   sample = tri_cnt;
      default:  sample = '0;
    endcase
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0); // R8

  AST_TRI_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode == WM_TRI) |=>
      (tri_cnt == DW'($past(tri_cnt) + 1'b1) || tri_cnt == DW'($past(tri_cnt) - 1'b1))); // R9

  AST_TRI_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(step && mode == WM_TRI) |=> $stable(tri_cnt)); // R11
endmodule

// File: rtl/dacw_channel.sv
module dacw_channel
  import dacw_pkg::*;
#(
  parameter int            DW   = 12,
  parameter int            LAT  = 3,
  parameter logic [DW-1:0] SEED = 'hACE,
  parameter logic [DW-1:0] TAPS = 'h829
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  input  logic             din_valid,
  output logic             din_ready,
  input  logic [DW-1:0]    din_data,
  input  logic             sw_trig,
  input  logic [NSRC-2:0]  ext_trig,
  output logic [DW-1:0]    dac_code
);
  ctl_t          cfg;
  wmode_e        mode;
  logic          hit;
  logic          fire;
  logic [DW-1:0] wsamp;
  logic [DW-1:0] fsamp;
  logic [DW-1:0] dhr;
  logic [DW-1:0] dor;

  dacw_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ctl_we),
    .wr_word (ctl_wdata),
    .cfg     (cfg)
  );

  assign mode = cfg.trig_en ? decode_wave(cfg.wave) : WM_NONE;

  dacw_wave #(.DW(DW), .SEED(SEED), .TAPS(TAPS)) u_wave (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (hit),
    .mode   (mode),
    .amp    (cfg.amp),
    .sample (wsamp)
  );

  dacw_trig #(.DW(DW), .LAT(LAT)) u_trig (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (cfg.en),
    .trig_en  (cfg.trig_en),
    .tsel     (cfg.tsel),
    .sw_trig  (sw_trig),
    .ext_trig (ext_trig),
    .samp_in  (wsamp),
    .hit      (hit),
    .fire     (fire),
    .samp_out (fsamp)
  );

  assign din_ready = 1'b1;
  assign ctl_rdata = CTL_W'(cfg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dhr <= '0;
      dor <= '0;
    end else begin
      if (din_valid) dhr <= din_data;
      if (cfg.en) begin
        if (!cfg.trig_en) dor <= dhr;
        else if (fire)    dor <= dhr + fsamp;
      end
    end
  end

  assign dac_code = dor;

  AST_DOR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_code) |-> $past(cfg.en)); // R6

  AST_DIRECT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.en && !cfg.trig_en) |=> dac_code == $past(dhr)); // R4
endmodule

// File: tb/tb_dacw_channel.sv
module tb_dacw_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [14:0] ctl_wdata = '0;
  logic [14:0] ctl_rdata;
  logic        din_valid = 1'b0;
  logic        din_ready;
  logic [11:0] din_data = '0;
  logic        sw_trig = 1'b0;
  logic [14:0] ext_trig = '0;
  logic [11:0] dac_code;

  int n_run = 0;
  int n_bad = 0;
  bit done = 0;

  logic [11:0] prev, lf, dat, exp_v;
  logic [3:0]  ts, idx;
  logic [1:0]  kind;
  logic        upd;

  always #4 clk = ~clk;

  dacw_channel dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .din_valid(din_valid), .din_ready(din_ready),
    .din_data(din_data), .sw_trig(sw_trig), .ext_trig(ext_trig),
    .dac_code(dac_code)
  );

  // entry: {tsel, kind(0 sw,1 ext,2 none), ext index, data, expect update}
  localparam logic [22:0] VEC [8] = '{
    {4'd0,  2'd0, 4'd0,  12'h123, 1'b1},
    {4'd1,  2'd1, 4'd1,  12'h234, 1'b1},
    {4'd7,  2'd1, 4'd7,  12'h345, 1'b1},
    {4'd15, 2'd1, 4'd15, 12'h456, 1'b1},
    {4'd3,  2'd1, 4'd4,  12'h567, 1'b0},
    {4'd0,  2'd1, 4'd1,  12'h678, 1'b0},
    {4'd5,  2'd0, 4'd0,  12'h789, 1'b0},
    {4'd9,  2'd1, 4'd9,  12'hABC, 1'b1}
  };

  function automatic logic [14:0] mk(bit en, bit te, logic [3:0] t, logic [1:0] w,
                                     logic [3:0] a, bit dma, bit udr, bit cal);
    return {cal, udr, dma, a, w, t, te, en};
  endfunction

  function automatic logic [11:0] lf_next(logic [11:0] l);
    return {l[10:0], l[11] ^ l[5] ^ l[3] ^ l[0]};
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [15:0] act, logic [15:0] expv);
    n_run++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic write_ctl(logic [14:0] w);
    ctl_wdata = w; ctl_we = 1'b1;
    tick();
    ctl_we = 1'b0;
  endtask

  task automatic write_data(logic [11:0] d);
    din_data = d; din_valid = 1'b1;
    tick();
    din_valid = 1'b0;
  endtask

  task automatic pulse(logic [1:0] k, logic [3:0] i);
    if (k == 2'd0) sw_trig = 1'b1;
    else if (k == 2'd1) ext_trig[i-1] = 1'b1;
    tick();
    sw_trig = 1'b0; ext_trig = '0;
  endtask

  initial begin
    #(8 * 60000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); tick();
    // R1 reset state
    check("R1 code", 16'(dac_code), 16'h0);
    check("R1 ctl", 16'(ctl_rdata), 16'h0);
    check("R1 ready", 16'(din_ready), 16'h1);
    rst_n = 1'b1;
    tick();

    // R2 readback of fields
    write_ctl(mk(0, 1, 4'hA, 2'b10, 4'h5, 1, 1, 0));
    check("R2 readback", 16'(ctl_rdata), 16'(mk(0, 1, 4'hA, 2'b10, 4'h5, 1, 1, 0)));
    write_ctl(mk(0, 0, 0, 0, 0, 0, 0, 0));
    check("R2 clear", 16'(ctl_rdata), 16'h0);

    // R3 calibration lock
    write_ctl(mk(0, 0, 0, 0, 0, 0, 0, 1));
    check("R3 cal set idle", 16'(ctl_rdata[14]), 16'h1);
    write_ctl(mk(1, 0, 0, 0, 0, 0, 0, 1));
    write_ctl(mk(1, 0, 0, 0, 0, 0, 0, 0));
    check("R3 cal ignored running", 16'(ctl_rdata[14]), 16'h1);
    write_ctl(mk(0, 0, 0, 0, 0, 0, 0, 0));
    check("R3 cal held on disable", 16'(ctl_rdata), 16'(mk(0, 0, 0, 0, 0, 0, 0, 1)));
    write_ctl(mk(0, 0, 0, 0, 0, 0, 0, 0));
    check("R3 cal cleared idle", 16'(ctl_rdata[14]), 16'h0);

    // R5 R6 trigger selection table
    for (int i = 0; i < 8; i++) begin
      {ts, kind, idx, dat, upd} = VEC[i];
      write_ctl(mk(1, 1, ts, 0, 0, 0, 0, 0));
      write_data(dat);
      tick();
      prev = dac_code;
      pulse(kind, idx);
      tick(); tick();
      check("R5 not before t+3", 16'(dac_code), 16'(prev));
      tick();
      check(upd ? "R5 transfer" : "R6 unselected ignored", 16'(dac_code), 16'(upd ? dat : prev));
    end

    // R4 direct transfer timing
    write_ctl(mk(1, 0, 0, 0, 0, 0, 0, 0));
    prev = dac_code;
    write_data(12'h5A5);
    check("R4 old at k", 16'(dac_code), 16'(prev));
    tick();
    check("R4 new at k+1", 16'(dac_code), 16'h5A5);

    // R7 wave ignored without triggering
    write_ctl(mk(1, 0, 0, 2'b10, 4'd3, 0, 0, 0));
    write_data(12'h333);
    tick();
    check("R7 no offset when trigger off", 16'(dac_code), 16'h333);

    // R6 disabled channel holds
    write_ctl(mk(0, 0, 0, 0, 0, 0, 0, 0));
    prev = dac_code;
    write_data(12'h111);
    tick(); tick(); tick();
    check("R6 disabled ignores data", 16'(dac_code), 16'(prev));
    write_ctl(mk(0, 1, 0, 0, 0, 0, 0, 0));
    pulse(0, 0);
    tick(); tick(); tick();
    check("R6 disabled ignores trigger", 16'(dac_code), 16'(prev));
    write_ctl(mk(1, 1, 0, 0, 0, 0, 0, 0));
    pulse(0, 0);
    tick(); tick(); tick();
    check("R6 re-enabled transfer", 16'(dac_code), 16'h111);

    // R8 noise with mask code 3
    lf = 12'hACE;
    write_ctl(mk(1, 1, 0, 2'b01, 4'd3, 0, 0, 0));
    write_data(12'h100);
    for (int k = 0; k < 6; k++) begin
      pulse(0, 0);
      tick(); tick(); tick();
      exp_v = 12'h100 + (lf & 12'h00F);
      check("R8 noise", 16'(dac_code), 16'(exp_v));
      lf = lf_next(lf);
    end

    // R10 saturated mask codes, with truncation
    write_ctl(mk(1, 1, 0, 2'b01, 4'd15, 0, 0, 0));
    write_data(12'hFFF);
    for (int k = 0; k < 3; k++) begin
      pulse(0, 0);
      tick(); tick(); tick();
      exp_v = 12'hFFF + lf;
      check("R10 code 15 full mask", 16'(dac_code), 16'(exp_v));
      lf = lf_next(lf);
    end
    write_ctl(mk(1, 1, 0, 2'b01, 4'd11, 0, 0, 0));
    pulse(0, 0);
    tick(); tick(); tick();
    exp_v = 12'hFFF + lf;
    check("R10 code 11 full mask", 16'(dac_code), 16'(exp_v));

    // R9 R7 R11 triangle via wave code 11, peak 3; counter untouched so far
    write_ctl(mk(1, 1, 0, 2'b11, 4'd1, 0, 0, 0));
    write_data(12'h010);
    for (int k = 0; k < 8; k++) begin
      pulse(0, 0);
      tick(); tick(); tick();
      case (k)
        0, 6:    exp_v = 12'h010;
        1, 5, 7: exp_v = 12'h011;
        2, 4:    exp_v = 12'h012;
        default: exp_v = 12'h013;
      endcase
      check("R9 triangle", 16'(dac_code), 16'(exp_v));
    end

    // R11 noise register frozen during triangle run
    write_ctl(mk(1, 1, 0, 2'b01, 4'd11, 0, 0, 0));
    write_data(12'h000);
    pulse(0, 0);
    tick(); tick(); tick();
    check("R11 noise untouched by triangle", 16'(dac_code), 16'(lf_next(lf)));
    check("R11 ready high", 16'(din_ready), 16'h1);

    // R1 reset mid-run
    rst_n = 1'b0;
    tick();
    check("R1 code after reset", 16'(dac_code), 16'h0);
    check("R1 ctl after reset", 16'(ctl_rdata), 16'h0);
    rst_n = 1'b1;

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule